// File: doc/BRIEF.md
# Multiprocessor-flag asynchronous serial transmitter

This block serialises bytes onto one output line for a network of processors sharing one serial link. Each frame carries a flag bit after its data field, which the receiving nodes use to tell address frames from data frames. The host writes a byte and the flag value through one write port. That write marks the holding register as full. On the next bit tick with the shifter idle, the byte moves into the shifter and the frame goes out: a low start bit, 7 or 8 data bits least significant first, the flag bit, then one or two high stop bits.

The holding register and the shifter form a double buffer. The host can write the next byte as soon as the holding register is reported empty, while the current frame is still going out. The holding register is checked as the final stop bit begins. A waiting byte is loaded at that point and its start bit directly follows the stop bit. With nothing waiting, an end flag is raised and the line stays high. Two level interrupt requests, each gated by its own enable, report the empty and end conditions. Each serial bit lasts one period of an external single-cycle bit tick.

Top module: `mptx_top`

## Requirements
- R1: After reset `tx_out` is 1, `buf_empty` is 1 and `tx_done` is 1. Whenever no frame is in progress the line is held at 1.
- R2: Each frame begins with exactly one 0 start bit lasting one tick period.
- R3: The data field follows the start bit, least significant bit first. It is 8 bits when `cfg_len7` is 0 and 7 bits when it is 1; in 7-bit mode bit 7 of the byte is never sent.
- R4: After the data field, one bit is sent equal to the `wr_mpb` value captured by the write that supplied the byte.
- R5: The frame ends with one 1 stop bit when `cfg_stop2` is 0, or two when it is 1.
- R6: When the holding register is full and the shifter is idle, the byte is loaded on the next `bit_tick` and the start bit appears. `buf_empty` returns to 1 in the same cycle.
- R7: If the holding register is full when the final stop bit begins, that byte is loaded then and its start bit directly follows the final stop bit, with no idle bit between.
- R8: If the holding register is empty when the final stop bit begins, `tx_done` becomes 1 with that bit and the line stays at 1 afterwards.
- R9: A write (`wr_en` = 1) sets `buf_empty` to 0 and `tx_done` to 0 on the next clock edge.
- R10: `irq_empty` always equals `buf_empty` AND `ie_empty`, and `irq_done` always equals `tx_done` AND `ie_done`.
- R11: `cfg_len7` and `cfg_stop2` are captured when a byte is loaded; changing them while that frame is going out does not alter it.
- R12: `tx_out` changes only on clock edges where `bit_tick` is 1, so each bit lasts exactly one tick period and no load occurs without a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | Single-cycle pulse marking each bit period |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to send |
| wr_mpb | input | 1 | Multiprocessor flag value for this byte |
| cfg_len7 | input | 1 | 1 = 7 data bits, 0 = 8 data bits |
| cfg_stop2 | input | 1 | 1 = two stop bits, 0 = one stop bit |
| ie_empty | input | 1 | Enable for the empty interrupt request |
| ie_done | input | 1 | Enable for the end interrupt request |
| tx_out | output | 1 | Serial output line |
| buf_empty | output | 1 | Holding register empty flag |
| tx_done | output | 1 | Transmission end flag |
| irq_empty | output | 1 | Empty interrupt request (level) |
| irq_done | output | 1 | End interrupt request (level) |

## Verification
A write changes the flags at the first clock edge after the strobe. Each serial bit appears at the clock edge that carries its tick, because the line is driven from a register. The load and the flag updates it causes land on that same edge, and the interrupt outputs follow the flags with no added delay. The bench therefore applies every stimulus at a falling edge. It samples line and flags at the next falling edge after the edge it expects to act, and compares each tick's sample against a bit sequence built from the bytes and formats it chose. Windows with no tick are also sampled, to confirm that the line and the flags hold.

// File: rtl/mptx_pkg.sv
package mptx_pkg;

   typedef enum logic [2:0] {
      SH_IDLE  = 3'd0,
      SH_START = 3'd1,
      SH_DATA  = 3'd2,
      SH_FLAG  = 3'd3,
      SH_STOPA = 3'd4,
      SH_STOPZ = 3'd5
   } sh_state_t;

   typedef struct packed {
      logic short_len;
      logic two_stop;
      logic flag_bit;
   } frame_fmt_t;

endpackage

// File: rtl/mptx_holdreg.sv
module mptx_holdreg #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_mpb,
   input  logic              take_i,
   input  logic              end_i,
   input  logic              ie_empty,
   input  logic              ie_done,
   output logic [DATA_W-1:0] hold_data_o,
   output logic              hold_mpb_o,
   output logic              empty_o,
   output logic              done_o,
   output logic              irq_empty_o,
   output logic              irq_done_o
);

   logic [DATA_W-1:0] data_q;
   logic              mpb_q;
   logic              empty_q;
   logic              done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         mpb_q  <= 1'b0;
      end else if (wr_en) begin
         data_q <= wr_data;
         mpb_q  <= wr_mpb;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         empty_q <= 1'b1;
         done_q  <= 1'b1;
      end else if (wr_en) begin
         empty_q <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         if (take_i) empty_q <= 1'b1;
         if (end_i)  done_q  <= 1'b1;
      end
   end

   assign hold_data_o = data_q;
   assign hold_mpb_o  = mpb_q;
   assign empty_o     = empty_q;
   assign done_o      = done_q;
   assign irq_empty_o = empty_q & ie_empty;
   assign irq_done_o  = done_q & ie_done;

   AST_WR_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (!empty_o && !done_o)); // R9

endmodule

// File: rtl/mptx_shifter.sv
module mptx_shifter
   import mptx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_tick,
   input  logic              full_i,
   input  logic [DATA_W-1:0] hold_data_i,
   input  logic              hold_mpb_i,
   input  logic              cfg_len7,
   input  logic              cfg_stop2,
   output logic              take_o,
   output logic              end_o,
   output logic              tx_o
);

   localparam int CNT_W   = $clog2(DATA_W + 1);
   localparam int LONG_N  = DATA_W;
   localparam int SHORT_N = DATA_W - 1;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("mptx_shifter: DATA_W must be at least 2");
      end
   endgenerate

   sh_state_t         state_q;
   frame_fmt_t        fmt_q;
   logic [DATA_W-1:0] shreg_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              pend_q;
   logic              tx_q;
   logic [CNT_W-1:0]  nbits;
   logic              stop_check;
   logic              idle_load;

   assign nbits = fmt_q.short_len ? CNT_W'(SHORT_N) : CNT_W'(LONG_N);

   // final stop bit begins on this tick
   assign stop_check = bit_tick &&
                       (((state_q == SH_FLAG) && !fmt_q.two_stop) ||
                        (state_q == SH_STOPA));
   assign idle_load  = bit_tick && (state_q == SH_IDLE) && full_i;

   assign take_o = idle_load || (stop_check && full_i);
   assign end_o  = stop_check && !full_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q <= '0;
         fmt_q   <= '0;
      end else if (take_o) begin
         shreg_q         <= hold_data_i;
         fmt_q.short_len <= cfg_len7;
         fmt_q.two_stop  <= cfg_stop2;
         fmt_q.flag_bit  <= hold_mpb_i;
      end else if (bit_tick && ((state_q == SH_START) || (state_q == SH_DATA))) begin
         shreg_q <= shreg_q >> 1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SH_IDLE;
         cnt_q   <= '0;
         pend_q  <= 1'b0;
         tx_q    <= 1'b1;
      end else if (bit_tick) begin
         unique case (state_q)
            SH_IDLE: begin
               if (full_i) begin
                  state_q <= SH_START;
                  tx_q    <= 1'b0;
               end else begin
                  tx_q    <= 1'b1;
               end
            end
            SH_START: begin
               state_q <= SH_DATA;
               tx_q    <= shreg_q[0];
               cnt_q   <= CNT_W'(1);
            end
            SH_DATA: begin
               if (cnt_q == nbits) begin
                  state_q <= SH_FLAG;
                  tx_q    <= fmt_q.flag_bit;
               end else begin
                  tx_q    <= shreg_q[0];
                  cnt_q   <= cnt_q + CNT_W'(1);
               end
            end
            SH_FLAG: begin
               tx_q <= 1'b1;
               if (fmt_q.two_stop) begin
                  state_q <= SH_STOPA;
               end else begin
                  state_q <= SH_STOPZ;
                  pend_q  <= full_i;
               end
            end
            SH_STOPA: begin
               tx_q    <= 1'b1;
               state_q <= SH_STOPZ;
               pend_q  <= full_i;
            end
            SH_STOPZ: begin
               if (pend_q) begin
                  state_q <= SH_START;
                  tx_q    <= 1'b0;
               end else begin
                  state_q <= SH_IDLE;
                  tx_q    <= 1'b1;
               end
               pend_q <= 1'b0;
            end
            default: begin
               state_q <= SH_IDLE;
               tx_q    <= 1'b1;
            end
         endcase
      end
   end

   assign tx_o = tx_q;

   AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_tick |=> $stable(tx_o)); // R12

endmodule

// File: rtl/mptx_top.sv
module mptx_top #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_tick,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_mpb,
   input  logic              cfg_len7,
   input  logic              cfg_stop2,
   input  logic              ie_empty,
   input  logic              ie_done,
   output logic              tx_out,
   output logic              buf_empty,
   output logic              tx_done,
   output logic              irq_empty,
   output logic              irq_done
);

   logic [DATA_W-1:0] hold_data;
   logic              hold_mpb;
   logic              take;
   logic              frame_end;

   mptx_holdreg #(.DATA_W(DATA_W)) u_hold (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_data     (wr_data),
      .wr_mpb      (wr_mpb),
      .take_i      (take),
      .end_i       (frame_end),
      .ie_empty    (ie_empty),
      .ie_done     (ie_done),
      .hold_data_o (hold_data),
      .hold_mpb_o  (hold_mpb),
      .empty_o     (buf_empty),
      .done_o      (tx_done),
      .irq_empty_o (irq_empty),
      .irq_done_o  (irq_done)
   );

   mptx_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_tick    (bit_tick),
      .full_i      (!buf_empty),
      .hold_data_i (hold_data),
      .hold_mpb_i  (hold_mpb),
      .cfg_len7    (cfg_len7),
      .cfg_stop2   (cfg_stop2),
      .take_o      (take),
      .end_o       (frame_end),
      .tx_o        (tx_out)
   );

   AST_LOAD_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !wr_en) |=> buf_empty); // R6

   AST_LOAD_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_tick |=> $stable(buf_empty) || !buf_empty); // R12

   AST_END_ON_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_done) |-> tx_out); // R8

   AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_done && buf_empty && $stable(tx_done)) |-> tx_out); // R1

endmodule

// File: tb/mptx_top_tb_top.sv
module mptx_top_tb_top;

   localparam int GAP = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       wr_mpb = 1'b0;
   logic       cfg_len7 = 1'b0;
   logic       cfg_stop2 = 1'b0;
   logic       ie_empty = 1'b1;
   logic       ie_done = 1'b1;
   logic       tx_out, buf_empty, tx_done, irq_empty, irq_done;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   mptx_top #(.DATA_W(8)) dut_i (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_en(wr_en),
      .wr_data(wr_data), .wr_mpb(wr_mpb), .cfg_len7(cfg_len7),
      .cfg_stop2(cfg_stop2), .ie_empty(ie_empty), .ie_done(ie_done),
      .tx_out(tx_out), .buf_empty(buf_empty), .tx_done(tx_done),
      .irq_empty(irq_empty), .irq_done(irq_done)
   );

   task automatic check(string tag, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic tick_once();
      @(negedge clk) bit_tick = 1'b1;
      @(negedge clk) bit_tick = 1'b0;
      repeat (GAP) @(negedge clk);
   endtask

   task automatic write_byte(logic [7:0] d, logic m);
      @(negedge clk);
      wr_data = d; wr_mpb = m; wr_en = 1'b1;
      @(negedge clk) wr_en = 1'b0;
   endtask

   function automatic int frame_len(logic s7, logic s2);
      return 1 + (s7 ? 7 : 8) + 1 + (s2 ? 2 : 1);
   endfunction

   task automatic check_irqs(logic iee, logic ied);
      check("R10 irq_empty", irq_empty, buf_empty & iee);
      check("R10 irq_done", irq_done, tx_done & ied);
   endtask

   // nfr frames sent back to back; each next byte written right after the
   // previous start bit, with its format applied mid-frame (R11)
   task automatic run_chain(int nfr, bit directed, logic [7:0] d0, logic m0,
                            logic s70, logic s20, logic iee, logic ied);
      logic [7:0] fd[4];
      logic       fm[4], f7[4], f2[4];
      int         st[4];
      int         eb[64];
      string      et[64];
      int         len = 0;
      int         last_stop = 0;
      int         nxt = 1;
      for (int k = 0; k < nfr; k++) begin
         fd[k] = (directed && k == 0) ? d0 : 8'($urandom);
         fm[k] = (directed && k == 0) ? m0 : 1'($urandom);
         f7[k] = (directed && k == 0) ? s70 : 1'($urandom);
         f2[k] = (directed && k == 0) ? s20 : 1'($urandom);
         st[k] = len;
         eb[len] = 0; et[len] = (k == 0) ? "R2 start" : "R7 chained start"; len++;
         for (int b = 0; b < (f7[k] ? 7 : 8); b++) begin
            eb[len] = fd[k][b]; et[len] = "R3 data"; len++;
         end
         eb[len] = fm[k]; et[len] = "R4 flag"; len++;
         for (int s = 0; s < (f2[k] ? 2 : 1); s++) begin
            eb[len] = 1; et[len] = "R5 stop"; len++;
         end
         last_stop = len - 1;
      end
      ie_empty = iee; ie_done = ied;
      cfg_len7 = f7[0]; cfg_stop2 = f2[0];
      write_byte(fd[0], fm[0]);
      check("R9 empty cleared", buf_empty, 0);
      check("R9 done cleared", tx_done, 0);
      check_irqs(iee, ied);
      for (int t = 0; t <= len; t++) begin
         tick_once();
         if (t < len) check(et[t], tx_out, eb[t]);
         else         check("R8 mark after end", tx_out, 1);
         check((t >= last_stop) ? "R8 done set" : "R7 done held", tx_done,
               (t >= last_stop) ? 1 : 0);
         check_irqs(iee, ied);
         for (int k = 0; k < nfr; k++)
            if (t == st[k]) check("R6 empty on load", buf_empty, 1);
         if (nxt < nfr && t == st[nxt-1]) begin
            cfg_len7 = f7[nxt]; cfg_stop2 = f2[nxt];
            write_byte(fd[nxt], fm[nxt]);
            nxt++;
         end else if (t == st[nfr-1]) begin
            cfg_len7 = ~f7[nfr-1]; cfg_stop2 = ~f2[nfr-1];
         end
      end
      tick_once();
      check("R1 idle line", tx_out, 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++; n_tests++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      check("R1 reset tx", tx_out, 1);
      check("R1 reset empty", buf_empty, 1);
      check("R1 reset done", tx_done, 1);
      rst_n = 1'b1;
      @(negedge clk);
      check_irqs(1'b1, 1'b1);
      tick_once();
      check("R1 idle no data", tx_out, 1);
      check("R1 idle empty", buf_empty, 1);

      // no tick: nothing loads, line holds (R12)
      write_byte(8'h5A, 1'b1);
      repeat (10) @(negedge clk);
      check("R12 no load without tick", buf_empty, 0);
      check("R12 line holds", tx_out, 1);
      tick_once();
      check("R12 start on tick", tx_out, 0);
      check("R6 empty on tick load", buf_empty, 1);
      for (int i = 0; i < 12; i++) tick_once();
      check("R8 done after frame", tx_done, 1);

      // directed single frames
      run_chain(1, 1'b1, 8'hA5, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
      run_chain(1, 1'b1, 8'hC3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
      run_chain(1, 1'b1, 8'h80, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
      run_chain(3, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);

      // random chains
      for (int r = 0; r < 25; r++)
         run_chain(1 + int'($urandom % 4), 1'b0, 8'h00, 1'b0, 1'b0, 1'b0,
                   1'($urandom), 1'($urandom));

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule